// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This unit returns the smaller or the larger of two floating-point operands, in single or in double precision, with one cycle of latency. In its default mode it follows the IEEE 754-2019 minimumNumber/maximumNumber rules: a number always wins against a NaN, even a signalling one. A second mode gives the older, NaN-propagating behaviour: any NaN operand makes the result NaN. Every NaN the unit produces is the canonical quiet NaN. When either operand is a signalling NaN, the invalid-operation flag is raised.

Operands travel in 64-bit containers. A single-precision value is valid only when its upper 32 bits are all ones (NaN-boxed). Single-precision results are always returned boxed. An operand that is not properly boxed is read as the canonical quiet NaN. The unit sits in a floating-point datapath: each cycle, the issue logic presents the operands with the operation and mode selects and a valid strobe, and takes the result and flag one cycle later.

Top module: `fp_minmax_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high; `result` and `invalid` for that operation appear in the same cycle.
- R2: With `nan_prop` low, if exactly one operand is a NaN (quiet or signalling), the result is the other operand, unchanged.
- R3: If both operands are NaN, the result is the canonical quiet NaN: 64'h7FF8000000000000 in double precision and 64'hFFFFFFFF7FC00000 in single precision.
- R4: With `nan_prop` high, any NaN operand yields the canonical quiet NaN of R3.
- R5: `invalid` is high when either operand is a signalling NaN, in both modes, and low otherwise. A signalling NaN has an all-ones exponent, a top fraction bit of 0 and a nonzero fraction.
- R6: Negative zero orders below positive zero: min(+0, -0) = -0 and max(+0, -0) = +0, in either operand order.
- R7: With `is_double` low, bits 63:32 of the result are all ones.
- R8: A single-precision operand whose bits 63:32 are not all ones is treated as the canonical quiet NaN. It never raises `invalid`, and it loses to a number in the default mode.
- R9: For two non-NaN operands, `sel_max` low returns the numerically smaller one and `sel_max` high the larger one. Infinities and subnormals are included.
- R10: In a cycle with `in_valid` low, `result` and `invalid` keep their previous values one cycle later.
- R11: With `is_double` high, all 64 bits form one double-precision operand, and the result is one of the two operands or the canonical double NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| sel_max | input | 1 | 1: maximum, 0: minimum |
| nan_prop | input | 1 | 1: NaN-propagating mode, 0: 2019 number-preferring mode |
| is_double | input | 1 | 1: double precision, 0: boxed single precision |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 64 | Selected value or canonical quiet NaN |
| invalid | output | 1 | A signalling NaN was an operand |

## Verification
The unit keeps its only state in the output register, so a wrong internal decision always shows at the ports in the first cycle after the operation. A wrong classification shows up as one of three errors: a NaN returned where a number should win, a non-canonical NaN pattern, or a flag that disagrees with the operand encodings. A wrong ordering shows up as the wrong operand, most visibly with signed zeros and values of opposite sign. A wrong precision path shows up as unboxed upper bits, or as a misread of an operand whose box is missing. Losing the hold behaviour shows as a result that changes after an idle cycle.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    localparam int FLEN     = 64;
    localparam int SP_W     = 32;
    localparam int DP_EXP_W = 11;
    localparam int DP_FRC_W = 52;
    localparam int SP_EXP_W = 8;
    localparam int SP_FRC_W = 23;
    localparam int BOX_W    = FLEN - SP_W;

    localparam logic [FLEN-1:0] DP_CANON_NAN = {1'b0, {DP_EXP_W{1'b1}}, 1'b1, {(DP_FRC_W-1){1'b0}}};
    localparam logic [SP_W-1:0] SP_CANON_NAN = {1'b0, {SP_EXP_W{1'b1}}, 1'b1, {(SP_FRC_W-1){1'b0}}};
    localparam logic [FLEN-1:0] SP_CANON_BOX = {{BOX_W{1'b1}}, SP_CANON_NAN};

    // Decoded view of one operand in the selected precision.
    typedef struct packed {
        logic            nan;
        logic            snan;
        logic [FLEN-1:0] key;   // unsigned order key, valid for non-NaN values
        logic [FLEN-1:0] bits;  // value as it would be returned (boxed if single)
    } opnd_t;

    // Registered output state.
    typedef struct packed {
        logic            valid;
        logic [FLEN-1:0] result;
        logic            invalid;
    } outreg_t;

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify #(
    parameter int EXP_W = 8,
    parameter int FRC_W = 23,
    localparam int W    = 1 + EXP_W + FRC_W
) (
    input  logic [W-1:0] raw,
    output logic         is_nan,
    output logic         is_snan,
    output logic [W-1:0] key
);
    logic             exp_ones;
    logic             frc_nz;
    logic             quiet_bit;

    always_comb begin
        exp_ones  = &raw[W-2:FRC_W];
        frc_nz    = |raw[FRC_W-1:0];
        quiet_bit = raw[FRC_W-1];
        is_nan    = exp_ones && frc_nz;
        is_snan   = is_nan && !quiet_bit;
        // Sign-magnitude to unsigned order: negatives flip all bits,
        // positives set the top bit. -0 maps just below +0.
        key       = raw[W-1] ? ~raw : {1'b1, raw[W-2:0]};
    end
endmodule

// File: rtl/fpmm_unpack.sv
module fpmm_unpack
    import fpmm_pkg::*;
(
    input  logic [FLEN-1:0] raw,
    input  logic            is_double,
    output opnd_t           opnd
);
    logic            dp_nan, dp_snan;
    logic [FLEN-1:0] dp_key;
    logic            sp_nan, sp_snan;
    logic [SP_W-1:0] sp_key;
    logic            boxed;

    fpmm_classify #(.EXP_W(DP_EXP_W), .FRC_W(DP_FRC_W)) u_dp (
        .raw(raw), .is_nan(dp_nan), .is_snan(dp_snan), .key(dp_key)
    );

    fpmm_classify #(.EXP_W(SP_EXP_W), .FRC_W(SP_FRC_W)) u_sp (
        .raw(raw[SP_W-1:0]), .is_nan(sp_nan), .is_snan(sp_snan), .key(sp_key)
    );

    always_comb begin
        boxed = &raw[FLEN-1:SP_W];
        if (is_double) begin
            opnd.nan  = dp_nan;
            opnd.snan = dp_snan;
            opnd.key  = dp_key;
            opnd.bits = raw;
        end else if (!boxed) begin
            opnd.nan  = 1'b1;
            opnd.snan = 1'b0;
            opnd.key  = '0;
            opnd.bits = SP_CANON_BOX;
        end else begin
            opnd.nan  = sp_nan;
            opnd.snan = sp_snan;
            opnd.key  = {{BOX_W{1'b0}}, sp_key};
            opnd.bits = raw;
        end
    end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
    parameter int W = 64
) (
    input  logic [W-1:0] key_a,
    input  logic [W-1:0] key_b,
    output logic         a_below_b
);
    always_comb a_below_b = key_a < key_b;
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
    import fpmm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [FLEN-1:0] op_a,
    input  logic [FLEN-1:0] op_b,
    input  logic            sel_max,
    input  logic            nan_prop,
    input  logic            is_double,
    output logic            out_valid,
    output logic [FLEN-1:0] result,
    output logic            invalid
);
    localparam int NOPS = 2;

    logic [FLEN-1:0] raw_ops [NOPS];
    opnd_t           ops     [NOPS];
    logic            a_below_b;
    outreg_t         state_d, state_q;

    assign raw_ops[0] = op_a;
    assign raw_ops[1] = op_b;

    for (genvar i = 0; i < NOPS; i++) begin : g_unpack
        fpmm_unpack u_unpack (
            .raw       (raw_ops[i]),
            .is_double (is_double),
            .opnd      (ops[i])
        );
    end

    fpmm_order #(.W(FLEN)) u_order (
        .key_a     (ops[0].key),
        .key_b     (ops[1].key),
        .a_below_b (a_below_b)
    );

    always_comb begin
        logic [FLEN-1:0] canon;
        logic            any_nan;
        state_d       = state_q;
        state_d.valid = in_valid;
        canon         = is_double ? DP_CANON_NAN : SP_CANON_BOX;
        any_nan       = ops[0].nan || ops[1].nan;
        if (in_valid) begin
            state_d.invalid = ops[0].snan || ops[1].snan;
            if ((ops[0].nan && ops[1].nan) || (nan_prop && any_nan)) begin
                state_d.result = canon;
            end else if (ops[0].nan) begin
                state_d.result = ops[1].bits;
            end else if (ops[1].nan) begin
                state_d.result = ops[0].bits;
            end else if (sel_max) begin
                state_d.result = a_below_b ? ops[1].bits : ops[0].bits;
            end else begin
                state_d.result = a_below_b ? ops[0].bits : ops[1].bits;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.result;
    assign invalid   = state_q.invalid;

endmodule

// File: rtl/fp_minmax_chk.sv
module fp_minmax_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic        is_double,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        invalid
);
    logic a_dsnan, b_dsnan, a_ssnan, b_ssnan, any_snan;

    always_comb begin
        a_dsnan  = (&op_a[62:52]) && !op_a[51] && (|op_a[50:0]);
        b_dsnan  = (&op_b[62:52]) && !op_b[51] && (|op_b[50:0]);
        a_ssnan  = (&op_a[63:32]) && (&op_a[30:23]) && !op_a[22] && (|op_a[21:0]);
        b_ssnan  = (&op_b[63:32]) && (&op_b[30:23]) && !op_b[22] && (|op_b[21:0]);
        any_snan = is_double ? (a_dsnan || b_dsnan) : (a_ssnan || b_ssnan);
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_flag_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (invalid == $past(any_snan)));
    assert_single_boxed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_double) |=> (&result[63:32]));
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(invalid)));
    assert_double_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_double) |=> (result == $past(op_a) || result == $past(op_b)
                                     || result == 64'h7FF8000000000000));
endmodule

bind fp_minmax_unit fp_minmax_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .is_double (is_double),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid)
);

// File: tb/fp_minmax_unit_bench.sv
module fp_minmax_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        sel_max = 1'b0;
    logic        nan_prop = 1'b0;
    logic        is_double = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [63:0] DNAN = 64'h7FF8000000000000;
    localparam logic [63:0] SNAN_BOXED = 64'hFFFFFFFF7FC00000;

    always #5 clk = ~clk;

    fp_minmax_unit u_fp_minmax_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sel_max(sel_max), .nan_prop(nan_prop), .is_double(is_double),
        .out_valid(out_valid), .result(result), .invalid(invalid)
    );

    // ---------------- reference model ----------------
    function automatic logic m_nan(input logic [63:0] v, input logic dbl);
        if (dbl) return v[62:52] == 11'h7FF && v[51:0] != 0;
        if (v[63:32] != 32'hFFFFFFFF) return 1'b1;
        return v[30:23] == 8'hFF && v[22:0] != 0;
    endfunction

    function automatic logic m_snan(input logic [63:0] v, input logic dbl);
        if (dbl) return v[62:52] == 11'h7FF && !v[51] && v[50:0] != 0;
        if (v[63:32] != 32'hFFFFFFFF) return 1'b0;
        return v[30:23] == 8'hFF && !v[22] && v[21:0] != 0;
    endfunction

    // true when x < y (both non-NaN), sign/magnitude reasoning
    function automatic logic m_less(input logic [63:0] x, input logic [63:0] y, input logic dbl);
        logic sx, sy;
        logic [62:0] mx, my;
        sx = dbl ? x[63] : x[31];
        sy = dbl ? y[63] : y[31];
        mx = dbl ? x[62:0] : {32'd0, x[30:0]};
        my = dbl ? y[62:0] : {32'd0, y[30:0]};
        if (sx != sy) return sx;
        if (!sx) return mx < my;
        return mx > my;
    endfunction

    function automatic logic [64:0] m_ref(input logic [63:0] a, input logic [63:0] b,
                                          input logic mx, input logic np, input logic dbl);
        logic na, nb, fl;
        logic [63:0] r, cn;
        na = m_nan(a, dbl);
        nb = m_nan(b, dbl);
        fl = m_snan(a, dbl) | m_snan(b, dbl);
        cn = dbl ? DNAN : SNAN_BOXED;
        if (na && nb) r = cn;
        else if ((na || nb) && np) r = cn;
        else if (na) r = b;
        else if (nb) r = a;
        else if (mx) r = m_less(a, b, dbl) ? b : a;
        else r = m_less(a, b, dbl) ? a : b;
        return {fl, r};
    endfunction

    function automatic string m_tag(input logic [63:0] a, input logic [63:0] b,
                                    input logic np, input logic dbl);
        logic na, nb;
        na = m_nan(a, dbl);
        nb = m_nan(b, dbl);
        if (!dbl && (a[63:32] != 32'hFFFFFFFF || b[63:32] != 32'hFFFFFFFF)) return "R8";
        if (na && nb) return "R3";
        if ((na || nb) && np) return "R4";
        if (na || nb) return "R2";
        if (dbl) return "R11";
        return "R9";
    endfunction

    // ---------------- stimulus helpers ----------------
    function automatic logic [63:0] pick_op(input logic dbl);
        logic [31:0] s;
        logic [63:0] d;
        int k;
        k = $urandom_range(0, 9);
        d = {$urandom(), $urandom()};
        s = $urandom();
        case (k)
            0: begin d = {d[63], 11'h7FF, 1'b1, d[50:0]}; s = {s[31], 8'hFF, 1'b1, s[21:0]}; end
            1: begin d = {d[63], 11'h7FF, 1'b0, d[50:1], 1'b1}; s = {s[31], 8'hFF, 1'b0, s[21:1], 1'b1}; end
            2: begin d = {d[63], 63'd0}; s = {s[31], 31'd0}; end
            3: begin d = {d[63], 11'h7FF, 52'd0}; s = {s[31], 8'hFF, 23'd0}; end
            4: begin d = {d[63], 11'd0, d[51:0]}; s = {s[31], 8'd0, s[22:0]}; end
            default: ;
        endcase
        if (dbl) return d;
        if (k == 5) return {d[63:32] & 32'hFFFF_FFFE, s};
        return {32'hFFFFFFFF, s};
    endfunction

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic mx,
                          input logic np, input logic dbl, input string tag);
        logic [64:0] exp_v;
        exp_v = m_ref(a, b, mx, np, dbl);
        @(negedge clk);
        op_a = a; op_b = b; sel_max = mx; nan_prop = np; is_double = dbl; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n_run++;
        if (out_valid !== 1'b1 || result !== exp_v[63:0] || invalid !== exp_v[64]) begin
            n_fail++;
            $display("FAIL %s (R1/R5) a=%h b=%h mx=%0b np=%0b dbl=%0b: got v=%0b r=%h nv=%0b exp v=1 r=%h nv=%0b",
                     tag, a, b, mx, np, dbl, out_valid, result, invalid, exp_v[63:0], exp_v[64]);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] hold_r;
        logic        hold_f;
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || result !== 64'd0 || invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got v=%0b r=%h nv=%0b exp 0/0/0", out_valid, result, invalid);
        end
        rst_n = 1'b1;

        // directed corners
        run_op(64'hFFFFFFFF00000000, 64'hFFFFFFFF80000000, 1'b0, 1'b0, 1'b0, "R6");
        run_op(64'hFFFFFFFF00000000, 64'hFFFFFFFF80000000, 1'b1, 1'b0, 1'b0, "R6");
        run_op(64'h8000000000000000, 64'h0000000000000000, 1'b0, 1'b0, 1'b1, "R6");
        run_op(64'h8000000000000000, 64'h0000000000000000, 1'b1, 1'b0, 1'b1, "R6");
        run_op(64'h7FF0000000000001, 64'h3FF0000000000000, 1'b0, 1'b0, 1'b1, "R2");
        run_op(64'hFFFFFFFF7F800001, 64'hFFFFFFFF40200000, 1'b1, 1'b0, 1'b0, "R2");
        run_op(64'h7FF0000000000001, 64'hFFF8000000000000, 1'b0, 1'b0, 1'b1, "R3");
        run_op(64'hFFFFFFFFFFC00001, 64'hFFFFFFFF7F800005, 1'b1, 1'b0, 1'b0, "R3");
        run_op(64'h7FF8000000000000, 64'h4000000000000000, 1'b1, 1'b1, 1'b1, "R4");
        run_op(64'hFFFFFFFF7F800001, 64'hFFFFFFFF3F800000, 1'b0, 1'b1, 1'b0, "R4");
        run_op(64'h0000000040200000, 64'hFFFFFFFFC0000000, 1'b1, 1'b0, 1'b0, "R8");
        run_op(64'h000000007F800001, 64'h000000007F800001, 1'b0, 1'b0, 1'b0, "R8");
        run_op(64'hFFF0000000000000, 64'h0000000000000001, 1'b0, 1'b0, 1'b1, "R9");
        run_op(64'hFFFFFFFFC0000000, 64'hFFFFFFFFBF800000, 1'b0, 1'b0, 1'b0, "R9");
        run_op(64'hFFFFFFFF40200000, 64'hFFFFFFFF40200000, 1'b1, 1'b0, 1'b0, "R7");

        // idle-cycle hold
        hold_r = result;
        hold_f = invalid;
        @(negedge clk);
        op_a = 64'h7FF0000000000001; op_b = 64'h1234; is_double = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || result !== hold_r || invalid !== hold_f) begin
            n_fail++;
            $display("FAIL R10 hold: got v=%0b r=%h nv=%0b exp v=0 r=%h nv=%0b",
                     out_valid, result, invalid, hold_r, hold_f);
        end

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic dbl, mx, np;
            logic [63:0] a, b;
            dbl = $urandom_range(0, 1);
            mx  = $urandom_range(0, 1);
            np  = $urandom_range(0, 3) == 0;
            a   = pick_op(dbl);
            b   = ($urandom_range(0, 15) == 0) ? a : pick_op(dbl);
            run_op(a, b, mx, np, dbl, m_tag(a, b, np, dbl));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule